// File: doc/BRIEF.md
# Split-Transaction Microframe Eligibility Checker

This block looks at one split isochronous transfer descriptor and decides, for the current microframe, whether the host should issue a start-split, a complete-split, or neither. It takes the descriptor's addressing word and schedule-control word, the descriptor's Active and split-state status bits, and a microframe tick. It keeps its own 14-bit frame index counter, which advances on every tick. The low three bits of that counter select one position in each of the two 8-bit microframe masks.

Each tick starts an evaluation. One clock after the counter advances, the block registers a start-split candidate flag, a complete-split candidate flag, the decoded device address and endpoint number, and a malformed-mask flag. The outputs then hold until the next tick. The block also checks the masks against the scheduling rules: exactly one start bit set, no complete bit on the start bit's position, and a non-empty complete mask whenever a complete-split is due. If a descriptor breaks any rule, the block reports it as malformed and suppresses both candidate flags.

Top module: `split_uframe_gate`

## Requirements
- R1: While reset is held, and right after it, `frameIdx` is 0 and `startCand`, `completeCand`, `badMask`, `devAddr` and `endPt` are all 0.
- R2: A tick with `idxLoad` low adds 1 to `frameIdx`, wrapping from 16383 to 0. When `idxLoad` is high, `frameIdx` takes `idxLoadVal` on that clock instead, and no count is added.
- R3: On the clock edge after a tick is sampled, the outputs `startCand`, `completeCand`, `badMask`, `devAddr` and `endPt` are evaluated from the already advanced `frameIdx`. At every other edge they hold their values.
- R4: When `active` is 0 at the evaluation edge, `startCand`, `completeCand` and `badMask` are all 0.
- R5: With `active` = 1, `splitState` = 0 and a well-formed mask, `startCand` equals bit `frameIdx[2:0]` of the start mask (`schedWord[7:0]`, where bit 0 is the first microframe) and `completeCand` is 0.
- R6: With `active` = 1, `splitState` = 1 and well-formed masks, `completeCand` equals bit `frameIdx[2:0]` of the complete mask (`schedWord[15:8]`) and `startCand` is 0.
- R7: With `active` = 1, a start mask with zero or more than one bit set raises `badMask` and forces both candidate flags to 0, whatever the split state.
- R8: With `active` = 1, a complete mask that shares any set bit with the start mask raises `badMask` and forces both candidates to 0.
- R9: With `active` = 1 and `splitState` = 1, an all-zero complete mask raises `badMask`. With `splitState` = 0, an all-zero complete mask alone is not malformed.
- R10: `devAddr` is `addrWord[6:0]` and `endPt` is `addrWord[11:8]`. The reserved bits `addrWord[31:12]`, `addrWord[7]` and `schedWord[31:16]` have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Microframe tick: advances the counter and starts an evaluation |
| idxLoad | input | 1 | Loads the frame index counter |
| idxLoadVal | input | 14 | Value for the frame index load |
| addrWord | input | 32 | Descriptor addressing word |
| schedWord | input | 32 | Descriptor schedule-control word (complete mask 15:8, start mask 7:0) |
| active | input | 1 | Descriptor Active status bit |
| splitState | input | 1 | Split-state bit: 0 = start phase, 1 = complete phase |
| startCand | output | 1 | Start-split candidate in this microframe |
| completeCand | output | 1 | Complete-split candidate in this microframe |
| badMask | output | 1 | Mask rule violation |
| devAddr | output | 7 | Decoded device address |
| endPt | output | 4 | Decoded endpoint number |
| frameIdx | output | 14 | Current frame index counter |

## Verification
The bench targets these corner cases, each with its own failure mode:
- **Index timing.** A design that indexes with the pre-tick counter value shows candidates shifted by one microframe.
- **Counter wrap.** The counter is loaded to 16383 and ticked; a counter that saturates or is wider fails here.
- **Start-mask count.** Two-bit and empty start masks are mixed with one-hot ones. Counting only "non-zero" instead of "exactly one" lets multi-bit masks through as candidates.
- **Overlap and empty complete mask.** Masks whose complete bit overlaps the start bit, and empty complete masks in both split phases, check that the empty-mask rule applies only in the complete phase.
- **Reserved bits.** Random reserved bits and input changes between ticks catch a decode that reads the wrong field or outputs that follow the inputs without a tick.

// File: rtl/split_gate_pkg.sv
package split_gate_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadStb;   // load frame index from external value
    logic advStb;    // advance frame index by one
    logic evalStb;   // register eligibility outputs
  } ctrlStrobes_t;

endpackage

// File: rtl/split_gate_ctrl.sv
module split_gate_ctrl
  import split_gate_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         tick,
  input  logic         idxLoad,
  output ctrlStrobes_t strobes
);

  logic evalPend;

  // Evaluation runs one clock after the tick, on the advanced index
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) evalPend <= 1'b0;
    else       evalPend <= tick;
  end

  always_comb begin
    strobes.loadStb = idxLoad;
    strobes.advStb  = tick & ~idxLoad;
    strobes.evalStb = evalPend;
  end

endmodule

// File: rtl/split_gate_dp.sv
module split_gate_dp
  import split_gate_pkg::*;
#(
  parameter int IDX_W  = 14,
  parameter int MF_SEL = 3,
  parameter int DEV_W  = 7,
  parameter int EP_W   = 4,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [IDX_W-1:0]  idxLoadVal,
  input  logic [WORD_W-1:0] addrWord,
  input  logic [WORD_W-1:0] schedWord,
  input  logic              active,
  input  logic              splitState,
  output logic              startCand,
  output logic              completeCand,
  output logic              badMask,
  output logic [DEV_W-1:0]  devAddr,
  output logic [EP_W-1:0]   endPt,
  output logic [IDX_W-1:0]  frameIdx
);

  localparam int MASK_W = 1 << MF_SEL;
  localparam int SMASK_LO = 0;
  localparam int CMASK_LO = MASK_W;
  localparam int EP_LO = 8;
  localparam int CNT_W = $clog2(MASK_W + 1);

  logic [MASK_W-1:0] sMask, cMask, overlapBits;
  logic [MF_SEL-1:0] slot;
  logic [CNT_W-1:0]  sCount;
  logic              startBad, overlapBad, compEmpty, anyBad;
  logic              sHit, cHit;
  logic [DEV_W-1:0]  devNext;
  logic [EP_W-1:0]   epNext;
  logic              unusedReserved;

  assign sMask = schedWord[SMASK_LO +: MASK_W];
  assign cMask = schedWord[CMASK_LO +: MASK_W];
  assign slot  = frameIdx[MF_SEL-1:0];
  assign devNext = addrWord[DEV_W-1:0];
  assign epNext  = addrWord[EP_LO +: EP_W];
  assign unusedReserved = ^{addrWord[WORD_W-1:EP_LO+EP_W], addrWord[EP_LO-1:DEV_W],
                            schedWord[WORD_W-1:CMASK_LO+MASK_W]};

  // Per-slot overlap of the two masks
  genvar g;
  generate
    for (g = 0; g < MASK_W; g++) begin : gOverlap
      assign overlapBits[g] = sMask[g] & cMask[g];
    end
  endgenerate

  always_comb begin
    sCount = '0;
    for (int i = 0; i < MASK_W; i++) sCount = sCount + CNT_W'(sMask[i]);
  end

  always_comb begin
    startBad   = (sCount != CNT_W'(1));
    overlapBad = |overlapBits;
    compEmpty  = splitState & (cMask == '0);
    anyBad     = active & (startBad | overlapBad | compEmpty);
    sHit       = sMask[slot];
    cHit       = cMask[slot];
  end

  // Frame index counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                frameIdx <= '0;
    else if (strobes.loadStb) frameIdx <= idxLoadVal;
    else if (strobes.advStb)  frameIdx <= frameIdx + IDX_W'(1);
  end

  // Registered eligibility outputs
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startCand    <= 1'b0;
      completeCand <= 1'b0;
      badMask      <= 1'b0;
      devAddr      <= '0;
      endPt        <= '0;
    end else if (strobes.evalStb) begin
      startCand    <= active & ~anyBad & ~splitState & sHit;
      completeCand <= active & ~anyBad &  splitState & cHit;
      badMask      <= anyBad;
      devAddr      <= devNext;
      endPt        <= epNext;
    end
  end

endmodule

// File: rtl/split_uframe_gate.sv
module split_uframe_gate
  import split_gate_pkg::*;
#(
  parameter int IDX_W  = 14,
  parameter int MF_SEL = 3,
  parameter int DEV_W  = 7,
  parameter int EP_W   = 4,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              idxLoad,
  input  logic [IDX_W-1:0]  idxLoadVal,
  input  logic [WORD_W-1:0] addrWord,
  input  logic [WORD_W-1:0] schedWord,
  input  logic              active,
  input  logic              splitState,
  output logic              startCand,
  output logic              completeCand,
  output logic              badMask,
  output logic [DEV_W-1:0]  devAddr,
  output logic [EP_W-1:0]   endPt,
  output logic [IDX_W-1:0]  frameIdx
);

  ctrlStrobes_t strobes;

  split_gate_ctrl i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .tick    (tick),
    .idxLoad (idxLoad),
    .strobes (strobes)
  );

  split_gate_dp #(
    .IDX_W (IDX_W), .MF_SEL(MF_SEL), .DEV_W(DEV_W), .EP_W(EP_W), .WORD_W(WORD_W)
  ) i_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .idxLoadVal   (idxLoadVal),
    .addrWord     (addrWord),
    .schedWord    (schedWord),
    .active       (active),
    .splitState   (splitState),
    .startCand    (startCand),
    .completeCand (completeCand),
    .badMask      (badMask),
    .devAddr      (devAddr),
    .endPt        (endPt),
    .frameIdx     (frameIdx)
  );

endmodule

// File: rtl/split_gate_chk.sv
module split_gate_chk #(
  parameter int IDX_W = 14
) (
  input logic             clk,
  input logic             rstN,
  input logic             tick,
  input logic             idxLoad,
  input logic [IDX_W-1:0] idxLoadVal,
  input logic             active,
  input logic             startCand,
  input logic             completeCand,
  input logic             badMask,
  input logic [IDX_W-1:0] frameIdx
);

  // R2
  counter_advance_chk: assert property (@(posedge clk) disable iff (!rstN)
    tick && !idxLoad |=> frameIdx == $past(frameIdx) + IDX_W'(1));

  // R2
  counter_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    idxLoad |=> frameIdx == $past(idxLoadVal));

  // R3
  output_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(tick, 2) |-> $stable(startCand) && $stable(completeCand) && $stable(badMask));

  // R4
  inactive_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(tick, 2) && !$past(active) |-> !startCand && !completeCand && !badMask);

  // R5 R6
  one_action_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(startCand && completeCand));

  // R7 R8 R9
  bad_suppress_chk: assert property (@(posedge clk) disable iff (!rstN)
    badMask |-> !startCand && !completeCand);

endmodule

bind split_uframe_gate split_gate_chk #(.IDX_W(IDX_W)) i_split_gate_chk (
  .clk          (clk),
  .rstN         (rstN),
  .tick         (tick),
  .idxLoad      (idxLoad),
  .idxLoadVal   (idxLoadVal),
  .active       (active),
  .startCand    (startCand),
  .completeCand (completeCand),
  .badMask      (badMask),
  .frameIdx     (frameIdx)
);

// File: tb/test_split_uframe_gate.sv
module test_split_uframe_gate;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tick = 1'b0;
  logic        idxLoad = 1'b0;
  logic [13:0] idxLoadVal = '0;
  logic [31:0] addrWord = '0;
  logic [31:0] schedWord = '0;
  logic        active = 1'b0;
  logic        splitState = 1'b0;
  logic        startCand, completeCand, badMask;
  logic [6:0]  devAddr;
  logic [3:0]  endPt;
  logic [13:0] frameIdx;

  int checks = 0;
  int errors = 0;
  logic [13:0] modelIdx = '0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  split_uframe_gate i_split_uframe_gate (
    .clk(clk), .rstN(rstN), .tick(tick), .idxLoad(idxLoad), .idxLoadVal(idxLoadVal),
    .addrWord(addrWord), .schedWord(schedWord), .active(active), .splitState(splitState),
    .startCand(startCand), .completeCand(completeCand), .badMask(badMask),
    .devAddr(devAddr), .endPt(endPt), .frameIdx(frameIdx)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic expBad(input logic [31:0] s, input logic act, input logic sp);
    logic [7:0] sm = s[7:0];
    logic [7:0] cm = s[15:8];
    return act && (($countones(sm) != 1) || ((sm & cm) != 0) || (sp && cm == 0));
  endfunction

  function automatic logic expStart(input logic [31:0] s, input logic act, input logic sp,
                                    input logic [13:0] idx);
    return act && !expBad(s, act, sp) && !sp && s[idx[2:0]];
  endfunction

  function automatic logic expComp(input logic [31:0] s, input logic act, input logic sp,
                                   input logic [13:0] idx);
    return act && !expBad(s, act, sp) && sp && s[8 + idx[2:0]];
  endfunction

  // One microframe: drive inputs with tick, then sample after the evaluation edge
  task automatic microframe(input logic [31:0] a, input logic [31:0] s, input logic act,
                            input logic sp, input string tag);
    @(negedge clk);
    addrWord = a; schedWord = s; active = act; splitState = sp; tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    modelIdx = modelIdx + 14'd1;
    check({tag, " R2 frameIdx"}, 32'(frameIdx), 32'(modelIdx));
    @(negedge clk);
    check({tag, " R5 startCand"}, 32'(startCand), 32'(expStart(s, act, sp, modelIdx)));
    check({tag, " R6 completeCand"}, 32'(completeCand), 32'(expComp(s, act, sp, modelIdx)));
    check({tag, " R7 R8 R9 badMask"}, 32'(badMask), 32'(expBad(s, act, sp)));
    check({tag, " R10 devAddr"}, 32'(devAddr), 32'(a[6:0]));
    check({tag, " R10 endPt"}, 32'(endPt), 32'(a[11:8]));
  endtask

  task automatic loadIdx(input logic [13:0] v);
    @(negedge clk);
    idxLoad = 1'b1; idxLoadVal = v;
    @(negedge clk);
    idxLoad = 1'b0;
    modelIdx = v;
    check("R2 load", 32'(frameIdx), 32'(v));
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic sC, cC, bM;
    void'($urandom(32'd4711));
    #35;
    // R1 during reset
    check("R1 frameIdx in reset", 32'(frameIdx), 0);
    check("R1 cands in reset", 32'({startCand, completeCand, badMask}), 0);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    check("R1 frameIdx after reset", 32'(frameIdx), 0);
    check("R1 outputs after reset", 32'({startCand, completeCand, badMask, devAddr, endPt}), 0);

    // Directed: start bit at slot 1 (index becomes 1 after first tick) - R5
    microframe(32'h0000_0A15, 32'h0000_F002, 1'b1, 1'b0, "dir start hit");
    // slot 2 misses start bit 1
    microframe(32'h0000_0A15, 32'h0000_F002, 1'b1, 1'b0, "dir start miss");
    // R6 complete mask covers slot 3
    microframe(32'h0000_0312, 32'h0000_F802, 1'b1, 1'b1, "dir complete hit");
    // R4 inactive with a bad mask
    microframe(32'h0000_0312, 32'h0000_0003, 1'b0, 1'b0, "dir R4 inactive");
    // R7 two start bits
    microframe(32'h0000_0312, 32'h0000_0030, 1'b1, 1'b0, "dir R7 two bits");
    // R7 empty start mask
    microframe(32'h0000_0312, 32'h0000_FF00, 1'b1, 1'b1, "dir R7 empty");
    // R8 overlap
    microframe(32'h0000_0312, 32'h0000_0101, 1'b1, 1'b1, "dir R8 overlap");
    // R9 empty complete in complete phase; then fine in start phase
    microframe(32'h0000_0312, 32'h0000_0001, 1'b1, 1'b1, "dir R9 empty comp");
    microframe(32'h0000_0312, 32'h0000_0001, 1'b1, 1'b0, "dir R9 empty comp start phase");
    // R10 reserved bits set everywhere
    microframe(32'hFFFF_F080, 32'hFFFF_0004, 1'b1, 1'b0, "dir R10 reserved");

    // R2 wrap
    loadIdx(14'h3FFF);
    microframe(32'h0000_0000, 32'h0000_FE01, 1'b1, 1'b0, "dir R2 wrap");
    check("R2 wrap to zero", 32'(frameIdx), 0);

    // R3 hold: change inputs without tick
    sC = startCand; cC = completeCand; bM = badMask;
    @(negedge clk);
    schedWord = 32'h0000_00FF; active = 1'b1; splitState = 1'b1; addrWord = 32'h0000_0F7F;
    repeat (3) @(negedge clk);
    check("R3 hold startCand", 32'(startCand), 32'(sC));
    check("R3 hold completeCand", 32'(completeCand), 32'(cC));
    check("R3 hold badMask", 32'(badMask), 32'(bM));
    check("R3 hold devAddr", 32'(devAddr), 0);

    // Random microframes
    for (int n = 0; n < 600; n++) begin
      logic [31:0] a, s;
      logic [7:0] sm, cm;
      logic act, sp;
      int sb;
      a = $urandom;
      sb = $urandom % 8;
      sm = 8'(1 << sb);
      cm = 8'($urandom) & ~sm;
      if ($urandom % 8 == 0) sm = 8'($urandom);
      if ($urandom % 8 == 0) cm = 8'($urandom);
      if ($urandom % 10 == 0) cm = 8'h00;
      act = ($urandom % 8) != 0;
      sp = 1'($urandom);
      s = {16'($urandom), cm, sm};
      if (n % 50 == 0) loadIdx(14'($urandom));
      microframe(a, s, act, sp, "rand");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule